// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block connects an on-chip requester, running on the system clock, to an external asynchronous static RAM. The default size is 512K words of 8 bits. The requester offers one access at a time on a valid/ready handshake: an address, write data and a read/write select. Each read returns its byte together with a one-cycle response strobe.

The controller sequences the memory's active-low chip-select, output-enable and write-strobe pins. Together with those pins it holds the address and drives write data on a split data bus. The bus has a separate output, input and drive-enable, so a pad cell can be placed outside the block.

All timing comes from parameters: the clock period and the memory's write-pulse, data-setup and access times, all in picoseconds. Each time is turned into a whole number of clocks. The sequencer is a six-state machine:

- `ST_IDLE` waits for a request.
- `ST_RD_WAIT` times the read.
- `ST_WR_ADDR` presents the address before the write strobe.
- `ST_WR_PULSE` holds the write strobe low.
- `ST_WR_HOLD` keeps the address and data after the strobe rises.
- `ST_TURN` is an idle bus-turnaround cycle with the chip deselected.

The transitions are:

- accept-read: `ST_IDLE` to `ST_RD_WAIT`.
- accept-write: `ST_IDLE` to `ST_WR_ADDR`.
- address-settled: `ST_WR_ADDR` to `ST_WR_PULSE`, after one clock.
- pulse-done: `ST_WR_PULSE` to `ST_WR_HOLD`, when the timer expires.
- release: `ST_WR_HOLD` to `ST_TURN`.
- read-done: `ST_RD_WAIT` to `ST_TURN`, when the timer expires and the data is captured.
- turnaround-done: `ST_TURN` to `ST_IDLE`.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset and whenever `req_ready` is high, the memory pins are idle: `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0, and `rsp_valid` is 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is then low for exactly READ_CYCLES+1 cycles for a read (`req_write`=0), or PULSE_CYCLES+3 cycles for a write (`req_write`=1).
- R3: From the cycle after acceptance, `mem_ce_n` is 0 for the whole access and is 1 in the final busy cycle. While `mem_ce_n` is 0, `mem_addr` equals the accepted address and does not change.
- R4: In a write, `mem_we_n` first goes low in the second busy cycle, one clock after `mem_ce_n` fell. It stays low for one unbroken run and only while `mem_ce_n` is 0. When the write ends, the memory holds the accepted byte.
- R5: `mem_oe_n` stays 1 for the whole of every write and whenever `mem_we_n` is 0.
- R6: `mem_dq_oe` is 1 while `mem_we_n` is 0 and for exactly one cycle after `mem_we_n` rises, and is 0 otherwise. While it is 1, `mem_dq_out` equals the accepted write data, even if `req_wdata` changes after acceptance. `mem_dq_oe` is never 1 while `mem_oe_n` is 0.
- R7: In a read, `mem_oe_n` is 0 for exactly READ_CYCLES cycles. `mem_dq_in` is sampled on the clock edge that ends the last of them. `rsp_valid` is 1 for the single cycle READ_CYCLES+1 after acceptance, with `rsp_rdata` holding the sampled byte.
- R8: The cycle counts are derived as follows, where ceil(t/clk) has a minimum of 1:
  - PULSE_CYCLES = max(ceil(T_WP_PS/CLK_PERIOD_PS), ceil(T_DS_PS/CLK_PERIOD_PS)).
  - READ_CYCLES = ceil(T_AA_PS/CLK_PERIOD_PS).
- R9: Request inputs presented while `req_ready` is 0 are ignored: the address, data and timing of the access in progress are unchanged. A request still held when `req_ready` returns to 1 is taken as a new access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Requester offers an access |
| req_ready | output | 1 | Controller can take an access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Byte to write |
| rsp_valid | output | 1 | One-cycle strobe: read data is valid |
| rsp_rdata | output | DATA_W | Byte returned by a read |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | DATA_W | Data the pad drives onto the memory bus |
| mem_dq_oe | output | 1 | Pad drive enable for `mem_dq_out` |
| mem_dq_in | input | DATA_W | Data received from the memory bus |

## Verification
The assertions place no constraint on the request inputs; they only rely on the block's reset having been applied. They do assume a memory that drives its data pins only while it is selected, with reads enabled and writes off, since the no-contention check is stated at the controller's pins alone.

The bench's memory model behaves that way:
- It returns the stored byte only after READ_CYCLES-1 whole cycles of an enabled read, and a poison byte before then.
- It commits a write at the moment the overlap of select and write strobe ends.

As a result, an early sample, a short pulse or a misplaced drive window shows up as wrong data.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_WAIT,
        ST_WR_ADDR,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_TURN
    } ctrl_state_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic dq_oe;
    } pin_set_t;

    localparam pin_set_t PINS_QUIET = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};

    // Whole clocks covering a time, never below one.
    function automatic int unsigned cycles_for(input int unsigned t_ps, input int unsigned clk_ps);
        int unsigned c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
    parameter int unsigned CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_req_latch.sv
module sram_req_latch #(
    parameter int unsigned ADDR_W = 19,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (capture) begin
            addr_q <= addr_in;
            data_q <= data_in;
        end
    end
endmodule

// File: rtl/sram_pin_reg.sv
module sram_pin_reg
    import sram_ctrl_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  pin_set_t pins_d,
    output pin_set_t pins_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pins_q <= PINS_QUIET;
        end else begin
            pins_q <= pins_d;
        end
    end
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rdata,
    output logic              valid
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
            valid <= 1'b0;
        end else begin
            valid <= capture;
            if (capture) begin
                rdata <= dq_in;
            end
        end
    end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W        = 19,
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned CLK_PERIOD_PS = 10000,
    parameter int unsigned T_WP_PS       = 8000,
    parameter int unsigned T_DS_PS       = 5000,
    parameter int unsigned T_AA_PS       = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int unsigned WE_CYCLES    = cycles_for(T_WP_PS, CLK_PERIOD_PS);
    localparam int unsigned SETUP_CYCLES = cycles_for(T_DS_PS, CLK_PERIOD_PS);
    localparam int unsigned READ_CYCLES  = cycles_for(T_AA_PS, CLK_PERIOD_PS);
    // Data is driven only while the strobe is low, so the pulse must also cover setup.
    localparam int unsigned PULSE_CYCLES = max_u(WE_CYCLES, SETUP_CYCLES);
    localparam int unsigned CNT_MAX      = max_u(PULSE_CYCLES, READ_CYCLES);
    localparam int unsigned CNT_W        = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_CYCLES - 1);
    localparam logic [CNT_W-1:0] READ_LD  = CNT_W'(READ_CYCLES - 1);

    ctrl_state_e      state_q, state_d;
    pin_set_t         pins_d, pins_q;
    logic             accept;
    logic             timer_load;
    logic [CNT_W-1:0] timer_val;
    logic             timer_done;
    logic             rd_capture;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (accept) state_d = req_write ? ST_WR_ADDR : ST_RD_WAIT;
            ST_RD_WAIT:  if (timer_done) state_d = ST_TURN;
            ST_WR_ADDR:  state_d = ST_WR_PULSE;
            ST_WR_PULSE: if (timer_done) state_d = ST_WR_HOLD;
            ST_WR_HOLD:  state_d = ST_TURN;
            ST_TURN:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode: pins for the coming state, registered so the pins never glitch.
    always_comb begin
        pins_d     = PINS_QUIET;
        timer_load = 1'b0;
        timer_val  = PULSE_LD;
        rd_capture = (state_q == ST_RD_WAIT) && timer_done;
        unique case (state_d)
            ST_IDLE:     pins_d = PINS_QUIET;
            ST_RD_WAIT:  pins_d = '{ce_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, dq_oe: 1'b0};
            ST_WR_ADDR:  pins_d = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
            ST_WR_PULSE: pins_d = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, dq_oe: 1'b1};
            ST_WR_HOLD:  pins_d = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b1};
            ST_TURN:     pins_d = PINS_QUIET;
            default:     pins_d = PINS_QUIET;
        endcase
        if (state_d != state_q) begin
            if (state_d == ST_WR_PULSE) begin
                timer_load = 1'b1;
                timer_val  = PULSE_LD;
            end else if (state_d == ST_RD_WAIT) begin
                timer_load = 1'b1;
                timer_val  = READ_LD;
            end
        end
    end

    sram_pin_reg u_pins (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_d (pins_d),
        .pins_q (pins_q)
    );

    sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (timer_val),
        .done     (timer_done)
    );

    sram_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (accept),
        .addr_in (req_addr),
        .data_in (req_wdata),
        .addr_q  (mem_addr),
        .data_q  (mem_dq_out)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) u_rdcap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (rd_capture),
        .dq_in   (mem_dq_in),
        .rdata   (rsp_rdata),
        .valid   (rsp_valid)
    );

    assign mem_ce_n  = pins_q.ce_n;
    assign mem_oe_n  = pins_q.oe_n;
    assign mem_we_n  = pins_q.we_n;
    assign mem_dq_oe = pins_q.dq_oe;
endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
    parameter int unsigned ADDR_W       = 19,
    parameter int unsigned DATA_W       = 8,
    parameter int unsigned PULSE_CYCLES = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe
);
    logic [15:0] we_lo_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_lo_cnt <= '0;
        end else if (!mem_we_n) begin
            we_lo_cnt <= we_lo_cnt + 16'd1;
        end else begin
            we_lo_cnt <= '0;
        end
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_valid));

    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

    a_r4_we_inside_ce: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n);

    a_r4_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (we_lo_cnt < 16'(PULSE_CYCLES)));

    a_r8_pulse_length: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_lo_cnt == 16'(PULSE_CYCLES)));

    a_r5_oe_off_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    a_r6_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    a_r6_hold_after_we: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> mem_dq_oe);

    a_r6_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

    a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .PULSE_CYCLES (PULSE_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .mem_ce_n   (mem_ce_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_async_ctrl_bench.sv
module sram_async_ctrl_bench;
    localparam int AW    = 6;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;
    localparam int CLK_PS = 10000;
    localparam int WP_PS  = 15000;
    localparam int DS_PS  = 25000;
    localparam int AA_PS  = 18000;
    // Expected counts worked out from R8.
    localparam int B_WE    = (WP_PS + CLK_PS - 1) / CLK_PS;
    localparam int B_DS    = (DS_PS + CLK_PS - 1) / CLK_PS;
    localparam int B_PULSE = (B_WE > B_DS) ? B_WE : B_DS;
    localparam int B_RD    = (AA_PS + CLK_PS - 1) / CLK_PS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq_out, mem_dq_in;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    sram_async_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_PS(CLK_PS),
        .T_WP_PS(WP_PS), .T_DS_PS(DS_PS), .T_AA_PS(AA_PS)
    ) u_sram_async_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // Memory model: slow reads, writes committed when the select/strobe overlap ends.
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] exp_mem [DEPTH];
    logic rd_active, wr_act;
    int rd_age = 0;
    assign rd_active = !mem_ce_n && !mem_oe_n && mem_we_n;
    assign wr_act    = !mem_ce_n && !mem_we_n;
    assign mem_dq_in = (rd_active && rd_age >= B_RD - 1) ? mem[mem_addr] : 8'hEE;

    always @(posedge clk) rd_age <= rd_active ? rd_age + 1 : 0;
    always @(negedge wr_act) mem[mem_addr] <= mem_dq_oe ? mem_dq_out : 8'h11;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // R6 monitor: the controller never drives while the memory may drive.
    always @(negedge clk) begin
        if (rst_n) chk(!(mem_dq_oe && !mem_oe_n), "R6 contention", mem_dq_oe, 0);
    end

    task automatic write_body(input int a, input logic [DW-1:0] d, input string tag);
        int busy = 0, we_lo = 0, we_first = 0, oe_lo = 0, hold = 0;
        bit addr_ok = 1, dq_ok = 1, prev_we_lo = 0;
        while (!req_ready) begin
            busy++;
            if (!mem_we_n) begin
                we_lo++;
                if (we_first == 0) we_first = busy;
                if (!mem_dq_oe || mem_dq_out != d || mem_ce_n) dq_ok = 0;
            end else if (prev_we_lo) begin
                if (mem_dq_oe) hold++;
            end else if (mem_dq_oe) begin
                dq_ok = 0;
            end
            prev_we_lo = !mem_we_n;
            if (busy < B_PULSE + 3 && (mem_ce_n || mem_addr != AW'(a))) addr_ok = 0;
            if (busy == B_PULSE + 3 && !mem_ce_n) addr_ok = 0;
            if (!mem_oe_n) oe_lo++;
            @(negedge clk);
        end
        chk(busy == B_PULSE + 3, {tag, " R2 write busy"}, busy, B_PULSE + 3);
        chk(we_lo == B_PULSE, {tag, " R8 pulse cycles"}, we_lo, B_PULSE);
        chk(we_first == 2, {tag, " R4 strobe start"}, we_first, 2);
        chk(addr_ok, {tag, " R3 addr/select"}, addr_ok, 1);
        chk(oe_lo == 0, {tag, " R5 oe during write"}, oe_lo, 0);
        chk(dq_ok && hold == 1, {tag, " R6 drive window"}, hold, 1);
        chk(mem[a] == d, {tag, " R4 stored byte"}, mem[a], d);
        exp_mem[a] = d;
    endtask

    task automatic read_body(input int a, input string tag);
        int busy = 0, oe_lo = 0, vcnt = 0, vat = 0;
        logic [DW-1:0] got = '0;
        bit addr_ok = 1;
        while (!req_ready) begin
            busy++;
            if (!mem_oe_n) oe_lo++;
            if (rsp_valid) begin vcnt++; vat = busy; got = rsp_rdata; end
            if (busy <= B_RD && (mem_ce_n || mem_addr != AW'(a))) addr_ok = 0;
            @(negedge clk);
        end
        chk(busy == B_RD + 1, {tag, " R2 read busy"}, busy, B_RD + 1);
        chk(oe_lo == B_RD, {tag, " R8 read cycles"}, oe_lo, B_RD);
        chk(vcnt == 1 && vat == B_RD + 1, {tag, " R7 strobe timing"}, vat, B_RD + 1);
        chk(got == exp_mem[a], {tag, " R7 read data"}, got, exp_mem[a]);
        chk(addr_ok, {tag, " R3 read addr"}, addr_ok, 1);
    endtask

    task automatic issue(input bit wr, input int a, input logic [DW-1:0] d);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        req_wdata = ~d;  // latched copy must be used (R6)
    endtask

    task automatic do_write(input int a, input logic [DW-1:0] d);
        issue(1'b1, a, d);
        write_body(a, d, "wr");
    endtask

    task automatic do_read(input int a);
        issue(1'b0, a, '0);
        read_body(a, "rd");
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin mem[i] = '0; exp_mem[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
        chk({mem_ce_n, mem_oe_n, mem_we_n} == 3'b111, "R1 strobes", {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
        chk(mem_dq_oe == 1'b0 && rsp_valid == 1'b0, "R1 drive/valid", {mem_dq_oe, rsp_valid}, 0);

        for (int a = 0; a < DEPTH; a++) do_write(a, DW'(a * 37 + 5));
        for (int a = 0; a < DEPTH; a++) do_read(a);
        for (int a = DEPTH - 2; a >= 0; a -= 2) do_write(a, DW'(~a ^ 8'h5A));
        for (int a = DEPTH - 1; a >= 0; a--) do_read(a);
        // Read then write then read of one location, back to back
        do_read(33); do_write(33, 8'hC3); do_read(33);
        chk(req_ready && mem_ce_n && mem_we_n && !mem_dq_oe, "R1 idle after traffic", req_ready, 1);

        // R9: request inputs changed during a write are ignored, then taken afterwards
        issue(1'b1, 10, 8'h3C);
        req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(20); req_wdata = 8'hFF;
        write_body(10, 8'h3C, "r9_busy");
        @(negedge clk);
        req_valid = 1'b0;
        read_body(20, "r9_held");
        chk(mem[10] == 8'h3C, "R9 write kept", mem[10], 8'h3C);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule